// File: doc/BRIEF.md
# DMA Channel Flag Command Unit

This block keeps three per-channel flag vectors for a multi-channel DMA engine: an error flag and an interrupt-request flag per channel, both raised by the engine, and a descriptor START bit per channel that software raises and the engine drops. Software changes the flags only through byte-wide, write-only command registers. Each command carries a channel number, so that only that one flag changes, or an all-channels bit, so that the whole vector changes at once.

There are three commands, each at its own byte offset. One clears error flags, one clears interrupt flags and one sets START bits. All three decode the command byte the same way. The channel number sits in bits 3..0 and the all-channels control sits in bit 6. Bits 7, 5 and 4 are reserved and have no effect. A read of any command register returns zero. The three vectors are driven straight to output ports for the engine and for the interrupt logic.

Top module: `dma_flag_cmd`

## Requirements
- R1: After reset, the error, interrupt and START vectors are all zero.
- R2: A write to the clear-error offset with bit 6 = 0 clears only the error flag of the channel in bits 3..0, on the clock edge that samples the write.
- R3: A write to the clear-error offset with bit 6 = 1 clears every error flag, whatever bits 3..0 hold.
- R4: Bits 7, 5 and 4 of a command byte are ignored. A command with any of them set acts exactly like the same command with those bits at zero.
- R5: Reading rdata returns 0x00 at every offset, whatever was written before.
- R6: A write to the clear-interrupt offset clears the interrupt flag of the channel in bits 3..0 when bit 6 = 0, and clears all interrupt flags when bit 6 = 1.
- R7: A write to the set-START offset sets the START bit of the channel in bits 3..0 when bit 6 = 0, and sets all START bits when bit 6 = 1.
- R8: A one-cycle pulse on an error or interrupt set input raises that flag on the next edge. If a software clear of the same flag comes in the same cycle, the flag still ends up set.
- R9: A one-cycle pulse on a START clear input drops that START bit on the next edge. If a software set of the same bit comes in the same cycle, the bit ends up set.
- R10: A flag vector does not change when there is no command for it and no hardware event. This covers a write to an unmapped offset and command values present while wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte offset of the command register |
| wdata | input | 8 | Command byte |
| rdata | output | 8 | Read data. Always zero |
| hw_err_set | input | NUM_CH | Per-channel error event pulses from the engine |
| hw_int_set | input | NUM_CH | Per-channel interrupt event pulses from the engine |
| hw_start_clr | input | NUM_CH | Per-channel transfer-begin pulses that drop START |
| err_flags | output | NUM_CH | Error flag vector |
| int_flags | output | NUM_CH | Interrupt-request flag vector |
| start_flags | output | NUM_CH | START bit vector |

## Verification
There is one register stage between any input and a flag output. A command write or a hardware pulse that the bench drives after a falling edge is taken in on the next rising edge, and the new vector is read at the falling edge after that. rdata is combinational, so it is checked in the same half cycle as the address that selects it. Every task drives its stimulus at a falling edge, holds it for exactly one cycle, and compares against a vector worked out from the requirements at the following falling edge. The cases where a software command and a hardware event meet in the same cycle are checked in that same window.

// File: rtl/flagcmd_pkg.sv
package flagcmd_pkg;

  // Command byte layout; the decoder depends on these positions.
  localparam int CMD_W      = 8;
  localparam int CH_FIELD_W = 4;
  localparam int ALL_BIT    = 6;

  // Command kinds, one per command register.
  typedef enum logic [1:0] {
    KIND_ERR_CLR   = 2'd0,
    KIND_INT_CLR   = 2'd1,
    KIND_START_SET = 2'd2
  } cmd_kind_e;

  localparam int NUM_KINDS = 3;

  // Decoded fields of one command byte.
  typedef struct packed {
    logic                  all_ch;
    logic [CH_FIELD_W-1:0] ch;
  } cmd_fields_t;

endpackage

// File: rtl/flagcmd_decode.sv
module flagcmd_decode
  import flagcmd_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 3,
  parameter int OFF_ERR   = 0,
  parameter int OFF_INT   = 1,
  parameter int OFF_START = 2
) (
  input  logic                  clk,
  input  logic                  rst_ok_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CMD_W-1:0]      wdata,
  output logic [NUM_KINDS-1:0]  hit,
  output logic [NUM_CH-1:0]     mask
);

  localparam int OFFS [NUM_KINDS] = '{OFF_ERR, OFF_INT, OFF_START};

  cmd_fields_t fld;
  logic [2:0]  rsvd_unused;

  assign fld.all_ch   = wdata[ALL_BIT];
  assign fld.ch       = wdata[CH_FIELD_W-1:0];
  assign rsvd_unused  = {wdata[7], wdata[5:4]};

  // One strobe per command register.
  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_hit
      always_comb begin
        hit[k] = wr_en && (addr == ADDR_W'(OFFS[k]));
      end
    end
  endgenerate

  // Channel mask shared by all kinds: all ones or a single channel.
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_mask
      always_comb begin
        mask[c] = fld.all_ch || (32'(fld.ch) == c);
      end
    end
  endgenerate

  AST_ONE_CMD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0(hit)); // R10
  AST_ALL_BIT_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && wdata[ALL_BIT]) |-> (&mask)); // R3
  AST_SINGLE_CH_MASK: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && !wdata[ALL_BIT] && (32'(wdata[CH_FIELD_W-1:0]) < NUM_CH))
      |-> ($countones(mask) == 1)); // R2

endmodule

// File: rtl/flagcmd_vec.sv
module flagcmd_vec #(
  parameter int NUM_CH  = 16,
  parameter bit SW_SETS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              sw_hit,
  input  logic [NUM_CH-1:0] sw_mask,
  input  logic [NUM_CH-1:0] hw_evt,
  output logic [NUM_CH-1:0] q
);

  logic [NUM_CH-1:0] sw_eff;
  logic [NUM_CH-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    sw_eff = sw_hit ? sw_mask : '0;
    q_en   = sw_hit || (|hw_evt);
  end

  generate
    if (SW_SETS) begin : g_set_by_sw
      // Software set has priority over the engine's clear.
      always_comb begin
        q_nxt = (q & ~hw_evt) | sw_eff;
      end

      AST_SW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ok_n)
        sw_hit |=> ((q & $past(sw_mask)) == $past(sw_mask))); // R7
      AST_HW_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ok_n)
        (|(hw_evt & ~sw_eff)) |=> ((q & $past(hw_evt & ~sw_eff)) == '0)); // R9
    end else begin : g_clr_by_sw
      // Hardware set has priority over the software clear.
      always_comb begin
        q_nxt = (q & ~sw_eff) | hw_evt;
      end

      AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ok_n)
        (|hw_evt) |=> ((q & $past(hw_evt)) == $past(hw_evt))); // R8
      AST_SW_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ok_n)
        (|(sw_eff & ~hw_evt)) |=> ((q & $past(sw_eff & ~hw_evt)) == '0)); // R2
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!sw_hit && (hw_evt == '0)) |=> $stable(q)); // R10

endmodule

// File: rtl/dma_flag_cmd.sv
module dma_flag_cmd
  import flagcmd_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 3,
  parameter int OFF_ERR   = 0,
  parameter int OFF_INT   = 1,
  parameter int OFF_START = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NUM_CH-1:0] hw_err_set,
  input  logic [NUM_CH-1:0] hw_int_set,
  input  logic [NUM_CH-1:0] hw_start_clr,
  output logic [NUM_CH-1:0] err_flags,
  output logic [NUM_CH-1:0] int_flags,
  output logic [NUM_CH-1:0] start_flags
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released through a short synchroniser.
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_ok_n = rst_sync[SYNC_STAGES-1];

  logic [NUM_KINDS-1:0] hit;
  logic [NUM_CH-1:0]    mask;

  flagcmd_decode #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .OFF_ERR   (OFF_ERR),
    .OFF_INT   (OFF_INT),
    .OFF_START (OFF_START)
  ) u_decode (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .hit      (hit),
    .mask     (mask)
  );

  flagcmd_vec #(.NUM_CH(NUM_CH), .SW_SETS(1'b0)) u_err (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .sw_hit   (hit[KIND_ERR_CLR]),
    .sw_mask  (mask),
    .hw_evt   (hw_err_set),
    .q        (err_flags)
  );

  flagcmd_vec #(.NUM_CH(NUM_CH), .SW_SETS(1'b0)) u_int (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .sw_hit   (hit[KIND_INT_CLR]),
    .sw_mask  (mask),
    .hw_evt   (hw_int_set),
    .q        (int_flags)
  );

  flagcmd_vec #(.NUM_CH(NUM_CH), .SW_SETS(1'b1)) u_start (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .sw_hit   (hit[KIND_START_SET]),
    .sw_mask  (mask),
    .hw_evt   (hw_start_clr),
    .q        (start_flags)
  );

  // Command registers are write-only; reads return zero.
  assign rdata = '0;

  AST_ERR_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (|hw_err_set) |=> ((err_flags & $past(hw_err_set)) == $past(hw_err_set))); // R8
  AST_START_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && (addr == ADDR_W'(OFF_START)) && wdata[ALL_BIT]) |=> (&start_flags)); // R7
  AST_INT_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && (addr == ADDR_W'(OFF_INT)) && wdata[ALL_BIT] && (hw_int_set == '0))
      |=> (int_flags == '0)); // R6

endmodule

// File: tb/sim_dma_flag_cmd.sv
module sim_dma_flag_cmd;

  localparam int N  = 16;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_ERR   = 3'd0;
  localparam logic [AW-1:0] A_INT   = 3'd1;
  localparam logic [AW-1:0] A_START = 3'd2;
  localparam logic [AW-1:0] A_NONE  = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic [N-1:0]  hw_err_set, hw_int_set, hw_start_clr;
  logic [N-1:0]  err_flags, int_flags, start_flags;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  dma_flag_cmd #(.NUM_CH(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hw_err_set(hw_err_set), .hw_int_set(hw_int_set),
    .hw_start_clr(hw_start_clr), .err_flags(err_flags),
    .int_flags(int_flags), .start_flags(start_flags)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus from a falling edge, then sample at the next one.
  task automatic cycle(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [N-1:0] es, input logic [N-1:0] is,
                       input logic [N-1:0] sc);
    wr_en = we; addr = a; wdata = d;
    hw_err_set = es; hw_int_set = is; hw_start_clr = sc;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
    hw_err_set = '0; hw_int_set = '0; hw_start_clr = '0;
  endtask

  task automatic fill_events;
    cycle(1'b0, A_NONE, 8'h00, '1, '1, '0);
  endtask

  task automatic t_reset;
    check("R1 err after reset", err_flags, '0);
    check("R1 int after reset", int_flags, '0);
    check("R1 start after reset", start_flags, '0);
  endtask

  task automatic t_err_single;
    fill_events();
    check("R8 hw error set", err_flags, '1);
    cycle(1'b1, A_ERR, 8'h05, '0, '0, '0);
    check("R2 clear err ch5", err_flags, 16'hFFDF);
    check("R10 int untouched by err cmd", int_flags, '1);
    cycle(1'b1, A_ERR, 8'h00, '0, '0, '0);
    check("R2 clear err ch0", err_flags, 16'hFFDE);
    cycle(1'b1, A_ERR, 8'h0F, '0, '0, '0);
    check("R2 clear err ch15", err_flags, 16'h7FDE);
  endtask

  task automatic t_err_all;
    fill_events();
    cycle(1'b1, A_ERR, 8'h43, '0, '0, '0);
    check("R3 clear all err", err_flags, '0);
  endtask

  task automatic t_reserved;
    fill_events();
    cycle(1'b1, A_ERR, 8'hB2, '0, '0, '0);
    check("R4 reserved bits ignored err", err_flags, 16'hFFFB);
    cycle(1'b1, A_INT, 8'h39, '0, '0, '0);
    check("R4 reserved bits ignored int", int_flags, 16'hFDFF);
  endtask

  task automatic t_int;
    fill_events();
    cycle(1'b1, A_INT, 8'h0A, '0, '0, '0);
    check("R6 clear int ch10", int_flags, 16'hFBFF);
    check("R10 err untouched by int cmd", err_flags, '1);
    cycle(1'b1, A_INT, 8'h40, '0, '0, '0);
    check("R6 clear all int", int_flags, '0);
  endtask

  task automatic t_start;
    cycle(1'b1, A_START, 8'h03, '0, '0, '0);
    check("R7 set start ch3", start_flags, 16'h0008);
    cycle(1'b0, A_NONE, 8'h00, '0, '0, 16'h0008);
    check("R9 hw clear start ch3", start_flags, '0);
    cycle(1'b1, A_START, 8'hF1, '0, '0, '0);
    check("R7 set all start", start_flags, '1);
    cycle(1'b0, A_NONE, 8'h00, '0, '0, 16'h00F0);
    check("R9 hw clear start group", start_flags, 16'hFF0F);
  endtask

  task automatic t_collisions;
    cycle(1'b1, A_ERR, 8'h40, '0, '0, '0);
    cycle(1'b1, A_ERR, 8'h04, 16'h0010, '0, '0);
    check("R8 hw err set beats sw clear", err_flags, 16'h0010);
    cycle(1'b1, A_INT, 8'h40, '0, 16'h8001, '0);
    check("R8 hw int set beats clear all", int_flags, 16'h8001);
    cycle(1'b1, A_START, 8'h07, '0, '0, 16'h0080);
    check("R9 sw start set beats hw clear", start_flags, 16'hFF8F);
  endtask

  task automatic t_no_effect;
    fill_events();
    cycle(1'b1, A_NONE, 8'h40, '0, '0, '0);
    check("R10 unmapped offset err", err_flags, '1);
    check("R10 unmapped offset int", int_flags, '1);
    cycle(1'b0, A_ERR, 8'h40, '0, '0, '0);
    check("R10 no strobe err", err_flags, '1);
    cycle(1'b0, A_START, 8'h00, '0, '0, '1);
    cycle(1'b0, A_START, 8'h40, '0, '0, '0);
    check("R10 no strobe start", start_flags, '0);
  endtask

  task automatic t_read;
    for (int a = 0; a < 8; a++) begin
      addr = AW'(a);
      #1;
      check("R5 read returns zero", {8'h00, rdata}, '0);
    end
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; addr = '0; wdata = '0;
    hw_err_set = '0; hw_int_set = '0; hw_start_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_err_single();
    t_err_all();
    t_reserved();
    t_int();
    t_start();
    t_collisions();
    t_no_effect();
    t_read();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule